// File: doc/BRIEF.md
# Chained waveform pointer sequencer

This block plays a frame of waveform segments into a sample sink using two cooperating stages. A control stage walks a list of 32-bit pointers held in a local memory. Each non-zero pointer is the word address of a waveform table. Loading a pointer into the data stage starts that stage at once. The data stage then copies a fixed-length run of samples from consecutive addresses to the sink, one sample for each pacing request. When the run ends, control passes back to the control stage, which fetches the next pointer.

A zero entry ends the frame. In single mode the block raises a done flag and goes idle. In continuous mode it reloads the frame base and starts over. The handoff takes only a few cycles, so the paced sample stream has no gap as long as pacing requests are spaced widely enough. A pacing request that arrives while the data stage has no pointer is recorded in a sticky underrun flag. Abort stops both stages at once.

Both memory read ports are asynchronous: the data is valid in the same cycle as the address.

Top module: `wave_chain_seq`

## Requirements
- R1: After reset `smp_wr_en`, `done` and `underrun` are 0, and pacing requests produce no writes.
- R2: After an accepted start, the control stage reads the list entry at `frame_base`, then the entries at consecutive word addresses. A non-zero entry loads the data stage and starts it with no further command. The first pacing request after the load writes the memory word at that pointer.
- R3: Each pacing request taken by the active data stage causes exactly one write, in the cycle after the request. Samples come from consecutive addresses starting at the pointer. Each 32-bit word is passed on unmodified, so a sample in bits 31:16 (second output of a slice) and a sample in bits 15:0 (first output) both keep their positions.
- R4: Each pointer yields exactly PERIODS_PER_BIT × SAMPLES_PER_PERIOD writes. After those writes the next list entry is fetched.
- R5: In single mode (`cont_mode` = 0 when start is accepted), a zero entry raises `done` and the block goes idle. Later pacing requests produce no writes.
- R6: In continuous mode, a zero entry causes the list address to reload to the latched frame base in the next cycle. The frame then repeats with no missed sample while pacing requests are at least 4 cycles apart.
- R7: A pacing request that arrives while the block is running and the data stage is waiting for a pointer sets `underrun`. The flag stays set until the next accepted start clears it.
- R8: `abort` stops both stages in the cycle it is sampled. From then on there are no writes until a new start, and `done` is not raised.
- R9: A pacing request while the block is idle causes no write and no underrun.
- R10: A start while the block is running is ignored, and the sample stream continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame (accepted only when idle) |
| abort | input | 1 | Stop both stages immediately |
| cont_mode | input | 1 | 1 = repeat the frame, 0 = play it once (latched at start) |
| frame_base | input | ADDR_W | Word address of the first list entry (latched at start) |
| pace_req | input | 1 | One-cycle pacing request from the PWM wrap |
| ptr_rd_addr | output | ADDR_W | Pointer list read address |
| ptr_rd_data | input | DATA_W | Pointer list read data (same cycle) |
| smp_rd_addr | output | ADDR_W | Sample read address |
| smp_rd_data | input | DATA_W | Sample read data (same cycle) |
| smp_wr_en | output | 1 | Sample write strobe to the sink |
| smp_wr_data | output | DATA_W | Sample written to the sink |
| done | output | 1 | Single-mode frame finished (sticky until start) |
| underrun | output | 1 | Sticky pacing underrun error |

## Verification
The bench builds the block with ADDR_W = 8, PERIODS_PER_BIT = 2 and SAMPLES_PER_PERIOD = 3, so each segment is only six samples long. This short length lets many segment handoffs and several full continuous-mode frame wraps fit into a short run. The narrow address space lets the bench model the whole memory, with a distinct computed word at every address. Spacing the pacing requests four cycles apart exercises the gapless wrap. Holding the request high continuously brings the underrun case within reach.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  typedef enum logic [1:0] {
    CTL_IDLE  = 2'd0,
    CTL_FETCH = 2'd1,
    CTL_WAIT  = 2'd2
  } ctl_state_e;

  // samples played for one list entry
  function automatic int unsigned seg_samples(int unsigned periods, int unsigned per_period);
    return periods * per_period;
  endfunction

  // counter width able to hold a value up to n
  function automatic int unsigned count_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/wcs_data_stage.sv
module wcs_data_stage #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned SEG_LEN = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              pace,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              active,
  output logic              seg_last,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data
);
  localparam int unsigned CNT_W = wcs_pkg::count_width(SEG_LEN);
  localparam logic [CNT_W-1:0] LEN_INIT = CNT_W'(SEG_LEN);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] remain;
  logic             take;

  assign take     = active && pace && !abort;
  assign seg_last = take && (remain == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      rd_addr <= '0;
      remain  <= '0;
      wr_en   <= 1'b0;
      wr_data <= '0;
    end else if (abort) begin
      active <= 1'b0;
      wr_en  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (load) begin
        active  <= 1'b1;
        rd_addr <= load_addr;
        remain  <= LEN_INIT;
      end else if (take) begin
        wr_en   <= 1'b1;
        wr_data <= rd_data;
        rd_addr <= rd_addr + ADDR_W'(1);
        remain  <= remain - ONE;
        if (remain == ONE) active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wcs_ctl_stage.sv
module wcs_ctl_stage #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              cont_mode,
  input  logic [ADDR_W-1:0] frame_base,
  input  logic [DATA_W-1:0] ptr_data,
  input  logic              seg_done,
  output logic [ADDR_W-1:0] ptr_addr,
  output logic              ptr_load,
  output logic [ADDR_W-1:0] load_addr,
  output logic              zero_seen,
  output logic              start_ok,
  output logic              running,
  output logic              done,
  output logic [ADDR_W-1:0] base_q,
  output logic              cont_q
);
  import wcs_pkg::*;

  ctl_state_e        state;
  logic [ADDR_W-1:0] list_addr;
  logic              fetching;
  logic              ptr_nonzero;

  assign fetching    = (state == CTL_FETCH) && !abort;
  assign ptr_nonzero = |ptr_data;
  assign ptr_addr    = list_addr;
  assign load_addr   = ptr_data[ADDR_W-1:0];
  assign ptr_load    = fetching && ptr_nonzero;
  assign zero_seen   = fetching && !ptr_nonzero;
  assign start_ok    = (state == CTL_IDLE) && start && !abort;
  assign running     = (state != CTL_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= CTL_IDLE;
      list_addr <= '0;
      base_q    <= '0;
      cont_q    <= 1'b0;
      done      <= 1'b0;
    end else if (abort) begin
      state <= CTL_IDLE;
    end else begin
      case (state)
        CTL_IDLE: if (start) begin
          state     <= CTL_FETCH;
          list_addr <= frame_base;
          base_q    <= frame_base;
          cont_q    <= cont_mode;
          done      <= 1'b0;
        end
        CTL_FETCH: begin
          if (ptr_nonzero) begin
            list_addr <= list_addr + ADDR_W'(1);
            state     <= CTL_WAIT;
          end else if (cont_q) begin
            list_addr <= base_q;
          end else begin
            done  <= 1'b1;
            state <= CTL_IDLE;
          end
        end
        CTL_WAIT: if (seg_done) state <= CTL_FETCH;
        default: state <= CTL_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wave_chain_seq.sv
module wave_chain_seq #(
  parameter int unsigned DATA_W             = 32,
  parameter int unsigned ADDR_W             = 12,
  parameter int unsigned PERIODS_PER_BIT    = 10,
  parameter int unsigned SAMPLES_PER_PERIOD = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              cont_mode,
  input  logic [ADDR_W-1:0] frame_base,
  input  logic              pace_req,
  output logic [ADDR_W-1:0] ptr_rd_addr,
  input  logic [DATA_W-1:0] ptr_rd_data,
  output logic [ADDR_W-1:0] smp_rd_addr,
  input  logic [DATA_W-1:0] smp_rd_data,
  output logic              smp_wr_en,
  output logic [DATA_W-1:0] smp_wr_data,
  output logic              done,
  output logic              underrun
);
  localparam int unsigned SEG_LEN = wcs_pkg::seg_samples(PERIODS_PER_BIT, SAMPLES_PER_PERIOD);

  // named internal events, also used by the checker
  logic              ptr_load;
  logic [ADDR_W-1:0] load_addr;
  logic              seg_last;
  logic              data_active;
  logic              zero_seen;
  logic              start_ok;
  logic              running;
  logic [ADDR_W-1:0] base_q;
  logic              cont_q;
  logic              starved_pace;

  wcs_ctl_stage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .abort      (abort),
    .cont_mode  (cont_mode),
    .frame_base (frame_base),
    .ptr_data   (ptr_rd_data),
    .seg_done   (seg_last),
    .ptr_addr   (ptr_rd_addr),
    .ptr_load   (ptr_load),
    .load_addr  (load_addr),
    .zero_seen  (zero_seen),
    .start_ok   (start_ok),
    .running    (running),
    .done       (done),
    .base_q     (base_q),
    .cont_q     (cont_q)
  );

  wcs_data_stage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEG_LEN(SEG_LEN)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (abort),
    .load      (ptr_load),
    .load_addr (load_addr),
    .pace      (pace_req),
    .rd_data   (smp_rd_data),
    .rd_addr   (smp_rd_addr),
    .active    (data_active),
    .seg_last  (seg_last),
    .wr_en     (smp_wr_en),
    .wr_data   (smp_wr_data)
  );

  assign starved_pace = running && pace_req && !data_active && !abort;

  always_ff @(posedge clk) begin
    if (!rst_n)            underrun <= 1'b0;
    else if (start_ok)     underrun <= 1'b0;
    else if (starved_pace) underrun <= 1'b1;
  end
endmodule

// File: rtl/wave_chain_seq_chk.sv
module wave_chain_seq_chk #(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              abort,
  input logic              pace_req,
  input logic              smp_wr_en,
  input logic              done,
  input logic              underrun,
  input logic              data_active,
  input logic              seg_last,
  input logic              ptr_load,
  input logic              zero_seen,
  input logic              cont_q,
  input logic [ADDR_W-1:0] base_q,
  input logic [ADDR_W-1:0] ptr_rd_addr
);
  // R3: a write only follows a pacing request
  a_r3_write_needs_pace: assert property (@(posedge clk) disable iff (!rst_n)
    smp_wr_en |-> $past(pace_req));

  // R2: a loaded pointer starts the data stage at once
  a_r2_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |=> data_active);

  // R4: the last sample of a segment releases the data stage
  a_r4_seg_end_stops: assert property (@(posedge clk) disable iff (!rst_n)
    seg_last |=> !data_active);

  // R5: done only while the data stage is stopped
  a_r5_done_means_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !data_active);

  // R6: a zero entry in continuous mode reloads the base
  a_r6_wrap_to_base: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_seen && cont_q) |=> (ptr_rd_addr == base_q));

  // R7: underrun is sticky until a start
  a_r7_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !start) |=> underrun);

  // R8: abort silences the data stage
  a_r8_abort_silences: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!smp_wr_en && !data_active));
endmodule

bind wave_chain_seq wave_chain_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .abort       (abort),
  .pace_req    (pace_req),
  .smp_wr_en   (smp_wr_en),
  .done        (done),
  .underrun    (underrun),
  .data_active (data_active),
  .seg_last    (seg_last),
  .ptr_load    (ptr_load),
  .zero_seen   (zero_seen),
  .cont_q      (cont_q),
  .base_q      (base_q),
  .ptr_rd_addr (ptr_rd_addr)
);

// File: tb/wave_chain_seq_tb.sv
module wave_chain_seq_tb;
  localparam int unsigned DW   = 32;
  localparam int unsigned AW   = 8;
  localparam int unsigned PPB  = 2;
  localparam int unsigned SPP  = 3;
  localparam int unsigned SEG  = PPB * SPP;
  localparam int unsigned MEMN = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, abort = 1'b0, cont_mode = 1'b0, pace_req = 1'b0;
  logic [AW-1:0] frame_base = '0;
  logic [AW-1:0] ptr_rd_addr, smp_rd_addr;
  logic [DW-1:0] ptr_rd_data, smp_rd_data, smp_wr_data;
  logic          smp_wr_en, done, underrun;

  logic [DW-1:0] mem [MEMN];
  logic [DW-1:0] exp_q [$];
  int            checks = 0, fails = 0;
  string         cur_req = "R3";

  always #5 clk = ~clk;

  assign ptr_rd_data = mem[ptr_rd_addr];
  assign smp_rd_data = mem[smp_rd_addr];

  wave_chain_seq #(.DATA_W(DW), .ADDR_W(AW), .PERIODS_PER_BIT(PPB),
                   .SAMPLES_PER_PERIOD(SPP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .cont_mode(cont_mode),
    .frame_base(frame_base), .pace_req(pace_req), .ptr_rd_addr(ptr_rd_addr),
    .ptr_rd_data(ptr_rd_data), .smp_rd_addr(smp_rd_addr), .smp_rd_data(smp_rd_data),
    .smp_wr_en(smp_wr_en), .smp_wr_data(smp_wr_data), .done(done), .underrun(underrun)
  );

  // distinct word per address, both halves vary
  function automatic logic [DW-1:0] word_at(int unsigned a);
    return (DW'(a) * 32'h0001_0003) ^ 32'h5A00_00A5;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver side of the scoreboard
  task automatic push_seg(input int unsigned ptr);
    for (int k = 0; k < int'(SEG); k++) exp_q.push_back(word_at((ptr + k) % MEMN));
  endtask

  task automatic pulse_start(input logic [AW-1:0] base, input logic cont);
    frame_base = base; cont_mode = cont; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
  endtask

  task automatic pace_burst(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      pace_req = 1'b1; @(negedge clk); pace_req = 1'b0;
      repeat (gap - 1) @(negedge clk);
    end
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (rst_n && smp_wr_en) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL %s: actual write %h expected no write", cur_req, smp_wr_data);
      end else begin
        check(cur_req, smp_wr_data, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int a = 0; a < int'(MEMN); a++) mem[a] = word_at(a);
    // frame A: two segments, then end
    mem[8'h10] = 32'h0000_0040; mem[8'h11] = 32'h0000_0080; mem[8'h12] = 32'h0;
    // frame B: two segments, then end (used in continuous mode)
    mem[8'h20] = 32'h0000_00C0; mem[8'h21] = 32'h0000_0040; mem[8'h22] = 32'h0;

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {29'd0, smp_wr_en, done, underrun}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: pacing while idle does nothing (monitor flags any write)
    cur_req = "R9";
    pace_burst(3, 2);
    @(negedge clk);
    check("R9", {31'd0, underrun}, 32'd0);

    // R2, R3, R4, R10: single frame, one ignored start mid-frame
    cur_req = "R3";
    push_seg(32'h40); push_seg(32'h80);
    pulse_start(8'h10, 1'b0);
    pace_burst(5, 4);
    cur_req = "R10";
    frame_base = 8'h20; start = 1'b1; @(negedge clk); start = 1'b0;
    pace_burst(7, 4);
    repeat (4) @(negedge clk);
    check("R4", 32'(exp_q.size()), 32'd0);
    check("R5", {31'd0, done}, 32'd1);
    check("R2", {31'd0, underrun}, 32'd0);
    // R5: no writes after done
    cur_req = "R5";
    pace_burst(3, 2);
    check("R5", {31'd0, done}, 32'd1);

    // R6: continuous mode, gapless wrap, then R8 abort mid-segment
    cur_req = "R6";
    for (int s = 0; s < 4; s++) begin push_seg(32'hC0); push_seg(32'h40); end
    for (int k = 0; k < 40; k++) void'(exp_q.pop_back()); // keep 8*6-40 = 8? trimmed below
    exp_q.delete();
    for (int s = 0; s < 3; s++) begin push_seg(32'hC0); push_seg(32'h40); end
    for (int k = 0; k < 3; k++) exp_q.push_back(word_at(32'hC0 + k));
    pulse_start(8'h20, 1'b1);
    check("R5", {31'd0, done}, 32'd0);
    pace_burst(39, 4);
    check("R6", 32'(exp_q.size()), 32'd0);
    check("R6", {31'd0, underrun}, 32'd0);
    cur_req = "R8";
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    pace_burst(4, 3);
    check("R8", {31'd0, done}, 32'd0);
    check("R8", {31'd0, smp_wr_en}, 32'd0);

    // R7: pacing held high starves the pointer handoff
    cur_req = "R7";
    push_seg(32'h40); push_seg(32'h80);
    pulse_start(8'h10, 1'b0);
    pace_req = 1'b1;
    repeat (20) @(negedge clk);
    pace_req = 1'b0;
    repeat (3) @(negedge clk);
    check("R7", {31'd0, underrun}, 32'd1);
    check("R7", 32'(exp_q.size()), 32'd0);
    check("R7", {31'd0, done}, 32'd1);
    repeat (3) @(negedge clk);
    check("R7", {31'd0, underrun}, 32'd1);
    // a new start clears the flag
    push_seg(32'h40);
    pulse_start(8'h10, 1'b0);
    check("R7", {31'd0, underrun}, 32'd0);
    pace_burst(6, 4);
    check("R2", 32'(exp_q.size()), 32'd0);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule